// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder with Acknowledge Decoder

This block connects seven active-low interrupt request lines to a processor that has a three-bit active-low priority level input. Every clock it finds the highest-numbered request that is low and presents that number, inverted, on its level outputs. A level of zero means nothing is pending, and seven is the most urgent. The processor compares the level against its own mask. Level seven cannot be masked, so it is always taken.

When the processor services an interrupt, it runs an acknowledge bus cycle. In that cycle the function code is all ones, the address strobe is low, the upper address bits are all ones, and the three address bits just above bit zero carry the level being serviced. The block recognises this cycle and pulls exactly one of seven active-low acknowledge lines low. In the same cycle it returns an eight-bit vector number for that level on the low data byte and signals data-transfer acknowledge. Each level has its own writable vector register. The registers reset to a base value plus the level number.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output takes its idle value after that edge: `ipl_n` = 3'b111, `iack_n` all ones, `dtack_n` = 1, `vec_oe` = 0 and `vec_out` = 0.
- R2: One clock after the requests are sampled, `ipl_n` equals the bitwise inverse of the highest level whose request is low. Bit i of `irq_n` is level i+1.
- R3: When no request is low, `ipl_n` becomes 3'b111 at the next clock.
- R4: Whenever the level-7 request (`irq_n[6]`) is low, `ipl_n` becomes 3'b000 at the next clock, whatever the other requests are.
- R5: An acknowledge cycle is one in which all of these hold: `fc` = 3'b111, `as_n` = 0, `addr[3:1]` is nonzero, and `addr[23:4]` is all ones. One clock after such a cycle, only `iack_n[addr[3:1]-1]` is low.
- R6: A clock with any other function code (such as 3'b101 or 3'b110), with `as_n` high, with an upper address bit at zero, or with `addr[3:1]` = 0 gives all `iack_n` high, `dtack_n` high, `vec_oe` low and `vec_out` = 0 at the next clock.
- R7: In the same cycle as the acknowledge output, `dtack_n` is low, `vec_oe` is high and `vec_out` holds the vector register of the serviced level.
- R8: After reset, the vector register of level L holds `VEC_BASE` + L.
- R9: A clock with `vec_we` high and `vec_sel` in 1..7 stores `vec_wdata` in that level's register. `vec_sel` = 0 changes no register.
- R10: If a level's register is written in the same clock as that level is acknowledged, the returned vector is the value from before the write. The next acknowledge returns the new value.
- R11: The acknowledge outputs stay asserted for as long as the acknowledge cycle persists. They are released one clock after `as_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 7 | Active-low requests, bit i is level i+1 |
| fc | input | 3 | Processor function code (cycle type) |
| as_n | input | 1 | Active-low address strobe |
| addr | input | 23 | Word address bits 23:1 |
| vec_we | input | 1 | Vector register write enable |
| vec_sel | input | 3 | Level whose vector register is written (0 ignored) |
| vec_wdata | input | 8 | Vector value to store |
| ipl_n | output | 3 | Registered active-low priority level to the processor |
| iack_n | output | 7 | Registered active-low acknowledge per level, bit i is level i+1 |
| dtack_n | output | 1 | Active-low transfer acknowledge during a vector return |
| vec_oe | output | 1 | High while `vec_out` should drive the low data byte |
| vec_out | output | 8 | Vector number for the serviced level |

## Verification
The bench uses the default level width of three and a 23-bit word address. This makes all seven acknowledge lines reachable, along with the all-ones upper address field that tells a real acknowledge apart from a near miss. It overrides `VEC_BASE` to 64. The reset vectors 65 to 71 are then distinct from every value the bench writes, so a register that missed its reset, a write with the wrong select, and a read that returned the new value too early each show up as a wrong byte.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int FC_W = 3;

  // Processor cycle types carried on the function code pins
  typedef enum logic [FC_W-1:0] {
    FC_USR_DATA = 3'b001,
    FC_USR_PROG = 3'b010,
    FC_SUP_DATA = 3'b101,
    FC_SUP_PROG = 3'b110,
    FC_INT_ACK  = 3'b111
  } fc_code_e;

endpackage

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
  parameter int LVL_W = 3,
  localparam int NUM_LVL = (1 << LVL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_n,
  output logic [LVL_W-1:0]   ipl_n
);

  logic [LVL_W-1:0] top_lvl;

  // Scan upward so the highest active level wins
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (!irq_n[i]) top_lvl = LVL_W'(i + 1);
    end
  end

  // Registered so a request change cannot glitch the code
  always_ff @(posedge clk) begin
    if (rst) ipl_n <= '1;
    else     ipl_n <= ~top_lvl;
  end

endmodule

// File: rtl/iack_cycle_decoder.sv
module iack_cycle_decoder
  import irq_prio_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int ADDR_HI = 23
) (
  input  logic [FC_W-1:0]    fc,
  input  logic               as_n,
  input  logic [ADDR_HI:1]   addr,
  output logic               hit,
  output logic [LVL_W-1:0]   lvl
);

  logic upper_ones;
  logic cycle_ack;

  assign lvl        = addr[LVL_W:1];
  assign upper_ones = &addr[ADDR_HI:LVL_W+1];
  assign cycle_ack  = (fc == FC_INT_ACK) && !as_n;
  assign hit        = cycle_ack && upper_ones && (lvl != '0);

endmodule

// File: rtl/irq_vector_bank.sv
module irq_vector_bank #(
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 24,
  localparam int DEPTH   = 1 << LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LVL_W-1:0] wsel,
  input  logic [VEC_W-1:0] wdata,
  input  logic             rd_en,
  input  logic [LVL_W-1:0] rd_lvl,
  output logic [VEC_W-1:0] rd_data
);

  // Entry 0 stands for "no level": it is never written and reads zero
  logic [VEC_W-1:0] vec_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_mem[0] <= '0;
      for (int i = 1; i < DEPTH; i++) vec_mem[i] <= VEC_W'(VEC_BASE + i);
    end else if (we && (wsel != '0)) begin
      vec_mem[wsel] <= wdata;
    end
  end

  // Synchronous read returns the value held before a same-edge write
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= vec_mem[rd_lvl];
    else            rd_data <= '0;
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int ADDR_HI  = 23,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 24,
  localparam int NUM_LVL = (1 << LVL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_n,
  input  logic [FC_W-1:0]    fc,
  input  logic               as_n,
  input  logic [ADDR_HI:1]   addr,
  input  logic               vec_we,
  input  logic [LVL_W-1:0]   vec_sel,
  input  logic [VEC_W-1:0]   vec_wdata,
  output logic [LVL_W-1:0]   ipl_n,
  output logic [NUM_LVL-1:0] iack_n,
  output logic               dtack_n,
  output logic               vec_oe,
  output logic [VEC_W-1:0]   vec_out
);

  logic             ack_hit;
  logic [LVL_W-1:0] ack_lvl;

  irq_prio_encoder #(.LVL_W(LVL_W)) u_enc (
    .clk   (clk),
    .rst   (rst),
    .irq_n (irq_n),
    .ipl_n (ipl_n)
  );

  iack_cycle_decoder #(.LVL_W(LVL_W), .ADDR_HI(ADDR_HI)) u_dec (
    .fc   (fc),
    .as_n (as_n),
    .addr (addr),
    .hit  (ack_hit),
    .lvl  (ack_lvl)
  );

  irq_vector_bank #(.LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vec (
    .clk     (clk),
    .rst     (rst),
    .we      (vec_we),
    .wsel    (vec_sel),
    .wdata   (vec_wdata),
    .rd_en   (ack_hit),
    .rd_lvl  (ack_lvl),
    .rd_data (vec_out)
  );

  // One registered acknowledge line per level
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_iack
    always_ff @(posedge clk) begin
      if (rst) iack_n[g] <= 1'b1;
      else     iack_n[g] <= !(ack_hit && (ack_lvl == LVL_W'(g + 1)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dtack_n <= 1'b1;
      vec_oe  <= 1'b0;
    end else begin
      dtack_n <= !ack_hit;
      vec_oe  <= ack_hit;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int LVL_W    = 3,
  parameter int ADDR_HI  = 23,
  localparam int NUM_LVL = (1 << LVL_W) - 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_LVL-1:0] irq_n,
  input logic [2:0]         fc,
  input logic               as_n,
  input logic [ADDR_HI:1]   addr,
  input logic [LVL_W-1:0]   ipl_n,
  input logic [NUM_LVL-1:0] iack_n,
  input logic               dtack_n,
  input logic               vec_oe
);

  logic               qual;
  logic [NUM_LVL-1:0] want_mask;

  assign qual = (fc == 3'b111) && !as_n && (addr[LVL_W:1] != '0)
                && (&addr[ADDR_HI:LVL_W+1]);
  assign want_mask = qual ? (NUM_LVL'(1) << LVL_W'(addr[LVL_W:1] - 1'b1)) : '0;

  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (iack_n == '1 && dtack_n && !vec_oe && ipl_n == '1)); // R1

  AST_IPL_NONE: assert property (@(posedge clk) disable iff (rst)
    (&irq_n) |=> (ipl_n == '1)); // R3

  AST_IPL_TOP: assert property (@(posedge clk) disable iff (rst)
    !irq_n[NUM_LVL-1] |=> (ipl_n == '0)); // R4

  AST_IACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~iack_n)); // R5

  AST_IACK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    qual |=> ((~iack_n) == $past(want_mask))); // R5

  AST_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !qual |=> (iack_n == '1 && dtack_n && !vec_oe)); // R6

  AST_VEC_RETURN: assert property (@(posedge clk) disable iff (rst)
    qual |=> (!dtack_n && vec_oe)); // R7

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.LVL_W(LVL_W), .ADDR_HI(ADDR_HI)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_n   (irq_n),
  .fc      (fc),
  .as_n    (as_n),
  .addr    (addr),
  .ipl_n   (ipl_n),
  .iack_n  (iack_n),
  .dtack_n (dtack_n),
  .vec_oe  (vec_oe)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  localparam int LVL_W    = 3;
  localparam int ADDR_HI  = 23;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 64;
  localparam int NUM_LVL  = 7;

  typedef struct {
    logic [2:0] ipl;
    logic [6:0] iack;
    logic       dtack;
    logic       oe;
    logic [7:0] vout;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [6:0]       irq_n = '1;
  logic [2:0]       fc = 3'b001;
  logic             as_n = 1'b1;
  logic [ADDR_HI:1] addr = '0;
  logic             vec_we = 1'b0;
  logic [2:0]       vec_sel = '0;
  logic [7:0]       vec_wdata = '0;
  logic [2:0]       ipl_n;
  logic [6:0]       iack_n;
  logic             dtack_n;
  logic             vec_oe;
  logic [7:0]       vec_out;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  exp_t sb_q[$];
  logic [7:0] mvec [1:7];

  always #10 clk = ~clk;

  irq_prio_ctrl #(
    .LVL_W(LVL_W), .ADDR_HI(ADDR_HI), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
  ) u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_n(irq_n), .fc(fc), .as_n(as_n), .addr(addr),
    .vec_we(vec_we), .vec_sel(vec_sel), .vec_wdata(vec_wdata),
    .ipl_n(ipl_n), .iack_n(iack_n), .dtack_n(dtack_n), .vec_oe(vec_oe),
    .vec_out(vec_out)
  );

  function automatic logic [ADDR_HI:1] mk_addr(input logic [19:0] up, input logic [2:0] lv);
    return {up, lv};
  endfunction

  function automatic logic [2:0] model_ipl(input logic [6:0] rq);
    logic [2:0] t = 3'd0;
    for (int i = 0; i < 7; i++) if (!rq[i]) t = 3'(i + 1);
    return ~t;
  endfunction

  task automatic step(input logic [6:0] rq, input logic [2:0] f, input logic a,
                      input logic [ADDR_HI:1] ad, input logic we, input logic [2:0] sel,
                      input logic [7:0] wd, input string tag);
    exp_t e;
    logic [2:0] lv;
    @(negedge clk);
    irq_n = rq; fc = f; as_n = a; addr = ad;
    vec_we = we; vec_sel = sel; vec_wdata = wd;
    lv = ad[3:1];
    e.ipl = model_ipl(rq);
    e.tag = tag;
    if (f == 3'b111 && !a && lv != 3'd0 && ad[ADDR_HI:4] == 20'hFFFFF) begin
      e.iack = ~(7'd1 << (lv - 3'd1));
      e.dtack = 1'b0; e.oe = 1'b1; e.vout = mvec[lv];
    end else begin
      e.iack = 7'h7F; e.dtack = 1'b1; e.oe = 1'b0; e.vout = 8'h00;
    end
    sb_q.push_back(e);
    if (we && sel != 3'd0) mvec[sel] = wd;
  endtask

  task automatic idle_step(input logic [6:0] rq, input string tag);
    step(rq, 3'b101, 1'b1, '0, 1'b0, 3'd0, 8'h00, tag);
  endtask

  task automatic ack_step(input logic [2:0] lv, input string tag);
    step(7'h7F, 3'b111, 1'b0, mk_addr(20'hFFFFF, lv), 1'b0, 3'd0, 8'h00, tag);
  endtask

  // Monitor: compare each expected item one clock after its stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (ipl_n !== e.ipl || iack_n !== e.iack || dtack_n !== e.dtack ||
            vec_oe !== e.oe || vec_out !== e.vout) begin
          fails++;
          $display("FAIL %s: got ipl=%b iack=%b dtack=%b oe=%b vec=%h exp ipl=%b iack=%b dtack=%b oe=%b vec=%h",
                   e.tag, ipl_n, iack_n, dtack_n, vec_oe, vec_out,
                   e.ipl, e.iack, e.dtack, e.oe, e.vout);
        end
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got still running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 1; i <= 7; i++) mvec[i] = 8'(VEC_BASE + i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (ipl_n !== 3'b111 || iack_n !== 7'h7F || dtack_n !== 1'b1 ||
        vec_oe !== 1'b0 || vec_out !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset: got ipl=%b iack=%b dtack=%b oe=%b vec=%h exp 111 1111111 1 0 00",
               ipl_n, iack_n, dtack_n, vec_oe, vec_out);
    end
    rst = 1'b0;

    idle_step(7'h7F, "R3 no requests");
    idle_step(7'b1111110, "R2 level 1 only");
    idle_step(7'b1101101, "R2 levels 2 and 5");
    idle_step(7'b1111011, "R2 level 3 only");
    idle_step(7'b0000000, "R4 all levels low");
    idle_step(7'b0111011, "R4 levels 7 and 3");
    idle_step(7'h7F, "R3 requests removed");

    for (int l = 1; l <= 7; l++) ack_step(3'(l), "R8 R5 R7 reset vector ack");

    step(7'h7F, 3'b101, 1'b0, mk_addr(20'hFFFFF, 3'd2), 1'b0, 3'd0, 8'h00, "R6 supervisor data code");
    step(7'h7F, 3'b110, 1'b0, mk_addr(20'hFFFFF, 3'd4), 1'b0, 3'd0, 8'h00, "R6 supervisor program code");
    step(7'h7F, 3'b111, 1'b1, mk_addr(20'hFFFFF, 3'd4), 1'b0, 3'd0, 8'h00, "R6 strobe high");
    step(7'h7F, 3'b111, 1'b0, mk_addr(20'hFFFFE, 3'd2), 1'b0, 3'd0, 8'h00, "R6 upper bit zero");
    step(7'h7F, 3'b111, 1'b0, mk_addr(20'h7FFFF, 3'd6), 1'b0, 3'd0, 8'h00, "R6 top bit zero");
    step(7'h7F, 3'b111, 1'b0, mk_addr(20'hFFFFF, 3'd0), 1'b0, 3'd0, 8'h00, "R6 level zero");

    step(7'b1011111, 3'b111, 1'b0, mk_addr(20'hFFFFF, 3'd6), 1'b0, 3'd0, 8'h00, "R2 R5 ack with request pending");

    step(7'h7F, 3'b001, 1'b1, '0, 1'b1, 3'd3, 8'hA5, "R9 write level 3");
    ack_step(3'd3, "R9 readback level 3");
    step(7'h7F, 3'b001, 1'b1, '0, 1'b1, 3'd0, 8'h11, "R9 write select zero");
    for (int l = 1; l <= 7; l++) ack_step(3'(l), "R9 select zero changed nothing");

    step(7'h7F, 3'b111, 1'b0, mk_addr(20'hFFFFF, 3'd5), 1'b1, 3'd5, 8'h5A, "R10 same-cycle write returns old");
    ack_step(3'd5, "R10 next ack returns new");

    ack_step(3'd2, "R11 ack held first");
    ack_step(3'd2, "R11 ack held second");
    step(7'h7F, 3'b111, 1'b1, mk_addr(20'hFFFFF, 3'd2), 1'b0, 3'd0, 8'h00, "R11 released after strobe rises");
    idle_step(7'h7F, "R11 stays released");

    wait (sb_q.size() == 0);
    @(posedge clk);
    #4;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule